// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address, a segment number together with an offset inside that segment, into a flat physical address. It keeps a small internal table with one entry per segment. Each entry holds the segment's starting physical address, the segment's length, and three access rights: read, write and execute. A separate count register sets how many table entries are in use. Supervisor code fills the table and the count register through a configuration port. A write is accepted only while the privilege input is high.

Each translation request carries a segment number, an offset and an access kind. One cycle later the block returns either the translated address or a trap code. Three checks run in a fixed order: the segment number against the count, then the offset against the segment length, then the access kind against the rights. The first check that fails sets the trap code. When all three pass, the result is the segment start plus the offset.

Top module: `segxlat_top`

## Requirements
- R1: After reset, `rsp_valid_o` and `cfg_err_o` are 0, the count register is 0 and every table entry is all zero, so any request returns trap 01.
- R2: Each cycle with `req_valid_i` high produces exactly one cycle of `rsp_valid_o` on the next cycle, in request order. No response appears without a request.
- R3: A segment number greater than or equal to the count register gives trap code 01. This check takes priority over both of the other checks.
- R4: An offset greater than or equal to the entry's length gives trap code 10. This check takes priority over the rights check.
- R5: The access kind is encoded as 00 = read, 01 = write, 10 = execute and 11 = reserved. The rights field has bit 0 = read, bit 1 = write and bit 2 = execute. An access whose right bit is clear, and any reserved access, gives trap code 11.
- R6: When all checks pass, the trap code is 00 and `rsp_addr_o` equals the entry start plus the zero-extended offset, taken modulo 2^BASE_W.
- R7: Whenever the trap code is not 00, `rsp_addr_o` is 0.
- R8: A privileged configuration write loads the count register from `cfg_len_i` when `cfg_sel_len_i` is 1. Otherwise it loads entry `cfg_idx_i` with start, length and rights. The new value applies to requests from the next cycle on.
- R9: A configuration write with `cfg_priv_i` low changes neither the table nor the count register. It sets `cfg_err_o`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_priv_i | input | 1 | Privilege level of the write |
| cfg_sel_len_i | input | 1 | 1 writes the count register, 0 writes a table entry |
| cfg_idx_i | input | SEG_W (4) | Entry selected for the write |
| cfg_base_i | input | BASE_W (32) | Segment start address |
| cfg_lim_i | input | OFS_W (16) | Segment length |
| cfg_perm_i | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| cfg_len_i | input | SEG_W+1 (5) | New count register value |
| cfg_err_o | output | 1 | Sticky flag for an unprivileged write |
| req_valid_i | input | 1 | Translation request strobe |
| req_seg_i | input | SEG_W (4) | Segment number |
| req_ofs_i | input | OFS_W (16) | Offset within the segment |
| req_acc_i | input | 2 | Access kind |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_addr_o | output | BASE_W (32) | Physical address, or 0 on a trap |
| rsp_trap_o | output | 2 | 00 ok, 01 bad segment, 10 over length, 11 rights |

## Verification
The bench targets requests that fail more than one check at once. One such request names a segment beyond the count whose entry also has a zero length. Another is over its length and also uses an access its rights forbid. A design with the check priority wrong would return 10 or 11 where 01 or 10 is expected. The bench also places a segment near the top of the address space so the sum must wrap, and it tests offsets exactly at and one below the length, which catch an off-by-one bound or a truncated adder. Unprivileged writes are followed by translations through the touched entry and the count register. A design that let such a write through would show the new start address or a changed trap code at the response port.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      TRAP_NONE = 2'b00,
      TRAP_SEG  = 2'b01,
      TRAP_LIM  = 2'b10,
      TRAP_PROT = 2'b11
   } trap_e;

   typedef enum logic [1:0] {
      ACC_RD  = 2'b00,
      ACC_WR  = 2'b01,
      ACC_EX  = 2'b10,
      ACC_RSV = 2'b11
   } acc_e;

   localparam int PERM_W  = 3;
   localparam int PERM_RD = 0;
   localparam int PERM_WR = 1;
   localparam int PERM_EX = 2;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
   parameter int SEG_CNT = 16,
   parameter int OFS_W   = 16,
   parameter int BASE_W  = 32,
   localparam int SEG_W  = $clog2(SEG_CNT),
   localparam int LEN_W  = SEG_W + 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     we_i,
   input  logic                     priv_i,
   input  logic                     sel_len_i,
   input  logic [SEG_W-1:0]         idx_i,
   input  logic [BASE_W-1:0]        base_i,
   input  logic [OFS_W-1:0]         lim_i,
   input  logic [seg_pkg::PERM_W-1:0] perm_i,
   input  logic [LEN_W-1:0]         len_i,
   input  logic [SEG_W-1:0]         rd_idx_i,
   output logic [BASE_W-1:0]        rd_base_o,
   output logic [OFS_W-1:0]         rd_lim_o,
   output logic [seg_pkg::PERM_W-1:0] rd_perm_o,
   output logic [LEN_W-1:0]         len_o,
   output logic                     err_o
);
   logic [BASE_W-1:0]          base_a [SEG_CNT];
   logic [OFS_W-1:0]           lim_a  [SEG_CNT];
   logic [seg_pkg::PERM_W-1:0] perm_a [SEG_CNT];
   logic [LEN_W-1:0]           len_q;
   logic                       err_q;
   logic                       wr_ok, wr_bad;

   assign wr_ok  = we_i &&  priv_i;
   assign wr_bad = we_i && !priv_i;

   for (genvar i = 0; i < SEG_CNT; i++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            base_a[i] <= '0;
            lim_a[i]  <= '0;
            perm_a[i] <= '0;
         end else if (wr_ok && !sel_len_i && (idx_i == SEG_W'(i))) begin
            base_a[i] <= base_i;
            lim_a[i]  <= lim_i;
            perm_a[i] <= perm_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         len_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (wr_ok && sel_len_i) len_q <= len_i;
         if (wr_bad)             err_q <= 1'b1;
      end
   end

   assign rd_base_o = base_a[rd_idx_i];
   assign rd_lim_o  = lim_a[rd_idx_i];
   assign rd_perm_o = perm_a[rd_idx_i];
   assign len_o     = len_q;
   assign err_o     = err_q;

   // R9
   err_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_bad |=> err_o);
   // R9
   err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_o |=> err_o);
   // R9
   len_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_bad || !we_i) |=> $stable(len_o));
   // R8
   len_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_ok && sel_len_i) |=> (len_o == $past(len_i)));
endmodule

// File: rtl/seg_check.sv
module seg_check #(
   parameter int SEG_CNT = 16,
   parameter int OFS_W   = 16,
   parameter int BASE_W  = 32,
   localparam int SEG_W  = $clog2(SEG_CNT),
   localparam int LEN_W  = SEG_W + 1
) (
   input  logic [SEG_W-1:0]           seg_i,
   input  logic [OFS_W-1:0]           ofs_i,
   input  logic [1:0]                 acc_i,
   input  logic [LEN_W-1:0]           len_i,
   input  logic [BASE_W-1:0]          base_i,
   input  logic [OFS_W-1:0]           lim_i,
   input  logic [seg_pkg::PERM_W-1:0] perm_i,
   output seg_pkg::trap_e             trap_o,
   output logic [BASE_W-1:0]          addr_o
);
   import seg_pkg::*;

   logic seg_bad, lim_bad, acc_ok;

   assign seg_bad = ({1'b0, seg_i} >= len_i);
   assign lim_bad = (ofs_i >= lim_i);

   always_comb begin
      unique case (acc_e'(acc_i))
         ACC_RD:  acc_ok = perm_i[PERM_RD];
         ACC_WR:  acc_ok = perm_i[PERM_WR];
         ACC_EX:  acc_ok = perm_i[PERM_EX];
         default: acc_ok = 1'b0;
      endcase
   end

   always_comb begin
      if (seg_bad)      trap_o = TRAP_SEG;
      else if (lim_bad) trap_o = TRAP_LIM;
      else if (!acc_ok) trap_o = TRAP_PROT;
      else              trap_o = TRAP_NONE;
   end

   assign addr_o = (trap_o == TRAP_NONE) ? (base_i + BASE_W'(ofs_i)) : '0;
endmodule

// File: rtl/segxlat_top.sv
module segxlat_top #(
   parameter int SEG_CNT = 16,
   parameter int OFS_W   = 16,
   parameter int BASE_W  = 32,
   localparam int SEG_W  = $clog2(SEG_CNT),
   localparam int LEN_W  = SEG_W + 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic              cfg_priv_i,
   input  logic              cfg_sel_len_i,
   input  logic [SEG_W-1:0]  cfg_idx_i,
   input  logic [BASE_W-1:0] cfg_base_i,
   input  logic [OFS_W-1:0]  cfg_lim_i,
   input  logic [2:0]        cfg_perm_i,
   input  logic [LEN_W-1:0]  cfg_len_i,
   output logic              cfg_err_o,
   input  logic              req_valid_i,
   input  logic [SEG_W-1:0]  req_seg_i,
   input  logic [OFS_W-1:0]  req_ofs_i,
   input  logic [1:0]        req_acc_i,
   output logic              rsp_valid_o,
   output logic [BASE_W-1:0] rsp_addr_o,
   output logic [1:0]        rsp_trap_o
);
   import seg_pkg::*;

   if (SEG_CNT < 2 || (SEG_CNT & (SEG_CNT - 1)) != 0) begin : g_bad_cnt
      $error("SEG_CNT must be a power of two, at least 2");
   end
   if (OFS_W < 1 || OFS_W > BASE_W) begin : g_bad_ofs
      $error("OFS_W must lie in 1..BASE_W");
   end

   logic [BASE_W-1:0]  ent_base;
   logic [OFS_W-1:0]   ent_lim;
   logic [PERM_W-1:0]  ent_perm;
   logic [LEN_W-1:0]   tbl_len;
   trap_e              chk_trap;
   logic [BASE_W-1:0]  chk_addr;

   seg_table #(.SEG_CNT(SEG_CNT), .OFS_W(OFS_W), .BASE_W(BASE_W)) u_tbl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i),
      .priv_i   (cfg_priv_i),
      .sel_len_i(cfg_sel_len_i),
      .idx_i    (cfg_idx_i),
      .base_i   (cfg_base_i),
      .lim_i    (cfg_lim_i),
      .perm_i   (cfg_perm_i),
      .len_i    (cfg_len_i),
      .rd_idx_i (req_seg_i),
      .rd_base_o(ent_base),
      .rd_lim_o (ent_lim),
      .rd_perm_o(ent_perm),
      .len_o    (tbl_len),
      .err_o    (cfg_err_o)
   );

   seg_check #(.SEG_CNT(SEG_CNT), .OFS_W(OFS_W), .BASE_W(BASE_W)) u_chk (
      .seg_i (req_seg_i),
      .ofs_i (req_ofs_i),
      .acc_i (req_acc_i),
      .len_i (tbl_len),
      .base_i(ent_base),
      .lim_i (ent_lim),
      .perm_i(ent_perm),
      .trap_o(chk_trap),
      .addr_o(chk_addr)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rsp_valid_o <= 1'b0;
         rsp_addr_o  <= '0;
         rsp_trap_o  <= TRAP_NONE;
      end else begin
         rsp_valid_o <= req_valid_i;
         if (req_valid_i) begin
            rsp_addr_o <= chk_addr;
            rsp_trap_o <= chk_trap;
         end
      end
   end

   // R2
   valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_valid_i |=> rsp_valid_o);
   // R2
   idle_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_valid_i |=> !rsp_valid_o);
   // R3
   seg_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && ({1'b0, req_seg_i} >= tbl_len)) |=> (rsp_trap_o == 2'b01));
   // R7
   trap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && rsp_trap_o != 2'b00) |-> (rsp_addr_o == '0));
endmodule

// File: tb/sim_segxlat_top.sv
`timescale 1ns/1ps
module sim_segxlat_top;
   localparam int SEG_CNT = 16;
   localparam int OFS_W   = 16;
   localparam int BASE_W  = 32;
   localparam int SEG_W   = 4;
   localparam int LEN_W   = 5;

   typedef struct {
      logic [BASE_W-1:0] addr;
      logic [1:0]        trap;
      string             req;
   } exp_t;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0, cfg_priv = 0, cfg_sel_len = 0;
   logic [SEG_W-1:0] cfg_idx = '0;
   logic [BASE_W-1:0] cfg_base = '0;
   logic [OFS_W-1:0] cfg_lim = '0;
   logic [2:0] cfg_perm = '0;
   logic [LEN_W-1:0] cfg_len = '0;
   logic cfg_err;
   logic req_valid = 0;
   logic [SEG_W-1:0] req_seg = '0;
   logic [OFS_W-1:0] req_ofs = '0;
   logic [1:0] req_acc = '0;
   logic rsp_valid;
   logic [BASE_W-1:0] rsp_addr;
   logic [1:0] rsp_trap;

   int total = 0, bad = 0;
   exp_t sb[$];

   logic [BASE_W-1:0] m_base [SEG_CNT];
   logic [OFS_W-1:0]  m_lim  [SEG_CNT];
   logic [2:0]        m_perm [SEG_CNT];
   logic [LEN_W-1:0]  m_len = '0;

   always #10 clk = ~clk;

   segxlat_top #(.SEG_CNT(SEG_CNT), .OFS_W(OFS_W), .BASE_W(BASE_W)) u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .cfg_we_i(cfg_we), .cfg_priv_i(cfg_priv), .cfg_sel_len_i(cfg_sel_len),
      .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base), .cfg_lim_i(cfg_lim),
      .cfg_perm_i(cfg_perm), .cfg_len_i(cfg_len), .cfg_err_o(cfg_err),
      .req_valid_i(req_valid), .req_seg_i(req_seg), .req_ofs_i(req_ofs),
      .req_acc_i(req_acc), .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
      .rsp_trap_o(rsp_trap)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // model of the requirements R3..R7
   task automatic issue(input logic [SEG_W-1:0] s, input logic [OFS_W-1:0] o,
                        input logic [1:0] a, input string req);
      exp_t e;
      logic ok_acc;
      @(posedge clk); #1;
      req_valid = 1; req_seg = s; req_ofs = o; req_acc = a;
      ok_acc = (a == 2'b11) ? 1'b0 : m_perm[s][a];
      e.req = req;
      if ({1'b0, s} >= m_len)  begin e.trap = 2'b01; e.addr = '0; end
      else if (o >= m_lim[s])  begin e.trap = 2'b10; e.addr = '0; end
      else if (!ok_acc)        begin e.trap = 2'b11; e.addr = '0; end
      else begin e.trap = 2'b00; e.addr = m_base[s] + BASE_W'(o); end
      sb.push_back(e);
   endtask

   task automatic gap();
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic wr_ent(input logic [SEG_W-1:0] i, input logic [BASE_W-1:0] b,
                         input logic [OFS_W-1:0] l, input logic [2:0] p, input bit priv);
      @(posedge clk); #1;
      req_valid = 0;
      cfg_we = 1; cfg_priv = priv; cfg_sel_len = 0;
      cfg_idx = i; cfg_base = b; cfg_lim = l; cfg_perm = p;
      @(posedge clk); #1;
      cfg_we = 0;
      if (priv) begin m_base[i] = b; m_lim[i] = l; m_perm[i] = p; end
   endtask

   task automatic wr_len(input logic [LEN_W-1:0] n, input bit priv);
      @(posedge clk); #1;
      req_valid = 0;
      cfg_we = 1; cfg_priv = priv; cfg_sel_len = 1; cfg_len = n;
      @(posedge clk); #1;
      cfg_we = 0;
      if (priv) m_len = n;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            check(0, "R2 unexpected response", 64'(rsp_addr), 64'(0));
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rsp_trap == e.trap, {e.req, " trap"}, 64'(rsp_trap), 64'(e.trap));
            check(rsp_addr == e.addr, {e.req, " addr"}, 64'(rsp_addr), 64'(e.addr));
         end
      end
   end

   initial begin
      for (int i = 0; i < SEG_CNT; i++) begin
         m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      check(rsp_valid == 0, "R1 valid at reset", 64'(rsp_valid), 0);
      check(cfg_err == 0, "R1 err at reset", 64'(cfg_err), 0);
      issue(0, 0, 2'b00, "R1 empty table");
      gap();

      wr_ent(0, 32'h1000_0000, 16'h0100, 3'b011, 1);
      wr_ent(1, 32'h0000_2000, 16'h0010, 3'b100, 1);
      wr_ent(3, 32'hFFFF_FFF0, 16'hFFFF, 3'b111, 1);
      wr_ent(5, 32'h0000_5000, 16'h0000, 3'b111, 1);
      wr_len(4, 1);

      issue(0, 16'h0020, 2'b00, "R6 read seg0");
      issue(0, 16'h00FF, 2'b01, "R6 write last byte");
      issue(0, 16'h0100, 2'b00, "R4 offset at length");
      issue(0, 16'h0010, 2'b10, "R5 exec on rw seg");
      issue(1, 16'h0005, 2'b10, "R6 exec seg1");
      issue(1, 16'h0005, 2'b00, "R5 read on exec-only");
      issue(1, 16'h0010, 2'b01, "R4 length over rights");
      issue(3, 16'h0020, 2'b01, "R6 wrapping sum");
      issue(3, 16'h0001, 2'b11, "R5 reserved access");
      issue(4, 16'h0000, 2'b00, "R3 seg equals count");
      issue(5, 16'h0000, 2'b00, "R3 seg over count with zero length");
      issue(2, 16'h0000, 2'b00, "R7 zeroed entry");
      gap();
      gap();

      wr_len(16, 1);
      issue(5, 16'h0000, 2'b00, "R8 count raised, zero length");
      issue(15, 16'h0000, 2'b10, "R8 last seg zero length");
      wr_ent(15, 32'h0ABC_0000, 16'h8000, 3'b001, 1);
      issue(15, 16'h7FFF, 2'b00, "R8 entry load visible");
      gap();

      wr_ent(0, 32'h7777_0000, 16'hFFFF, 3'b111, 0);
      check(cfg_err == 1, "R9 err after unprivileged write", 64'(cfg_err), 1);
      issue(0, 16'h0004, 2'b00, "R9 entry kept");
      issue(0, 16'h0200, 2'b00, "R9 length kept");
      gap();
      wr_len(0, 0);
      issue(1, 16'h0003, 2'b10, "R9 count kept");
      gap();
      wr_ent(1, 32'h0, 16'h0, 3'b000, 1);
      check(cfg_err == 1, "R9 err sticky", 64'(cfg_err), 1);
      issue(1, 16'h0000, 2'b10, "R4 after reload");
      gap();
      repeat (3) @(posedge clk);
      #1;
      check(sb.size() == 0, "R2 missing responses", 64'(sb.size()), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule